// File: doc/BRIEF.md
# Dual-Output Power Sequencer Controller

This controller decides when each of two step-down regulator channels is told to start and when it is told to stop. A channel is enabled only when its hardware enable pin and its software enable bit are both high. No channel may start until the supply lockout has been clear for 10 ms. A 2-bit mode then either lets each channel follow its own enable, starts both channels together, or starts one channel and holds the other back until the first reports good and a programmable gap has run out.

Each channel has a start request and a ramp-active flag. The ramp-active flag stays high for the selected soft-start time after the request rises. One supervisor output reports that every enabled channel is at or above 90% of its target. It is driven as an active-low pull-down enable. In the immediate mode it follows the comparators in the same cycle. In the hold mode it waits until the channels have been good without a break for 125 ms. All timing comes from a timebase tick with a 0.5 ms period.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `uvlo_ok` is low, both `start_req` bits and both `ramp_on` bits are 0. After `uvlo_ok` rises, no start request goes high until 20 ticks (10 ms) have been counted.
- R2: Channel i is enabled when `hw_en[i]` and `sw_en[i]` are both 1. Clearing either bit clears `start_req[i]` on the next clock.
- R3: With `seq_mode` = 2'b01, channel 0 starts first. Channel 1 starts only after channel 0 has been requested and its `pg_in[0]` is high, and the gap has run out.
- R4: With `seq_mode` = 2'b10, channel 1 starts first and channel 0 follows on the same gap rule.
- R5: With `seq_mode` = 2'b11, both requests rise on the same clock, and only once both channels are enabled.
- R6: With `seq_mode` = 2'b00, each request follows only its own enable, with no ordering.
- R7: The gap is `gap_ms`×2 ticks, and any `gap_ms` above 50 acts as 50. With `gap_ms` = 0, the second request rises one clock after the first channel's good flag is seen.
- R8: `ramp_on[i]` rises with `start_req[i]` and stays high for 1, 2, 8 or 16 ticks (0.5, 1, 4, 8 ms) for `ramp_sel` = 0, 1, 2, 3.
- R9: With `hold_mode` = 0, the supervisor is asserted in the same cycle that lockout has cleared, at least one channel is enabled, and every enabled channel has `pg_in` high.
- R10: With `hold_mode` = 1, the supervisor asserts only after the R9 condition has held for 250 ticks (125 ms). Any break in it deasserts the supervisor at once and restarts the count from zero.
- R11: `pgood_pull_dn` is the inverse of the supervisor state: 1 pulls the line low (not good), and 0 releases it (good).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 0.5 ms |
| uvlo_ok | input | 1 | Supply lockout clear |
| hw_en | input | 2 | Hardware enable pins, one per channel |
| sw_en | input | 2 | Software enable bits, one per channel |
| seq_mode | input | 2 | 00 independent, 01 ch0 first, 10 ch1 first, 11 together |
| gap_ms | input | 6 | Inter-channel gap in ms, clamped to 50 |
| ramp_sel | input | 2 | Soft-start time select |
| hold_mode | input | 1 | 0 immediate power-good, 1 reset-style hold |
| pg_in | input | 2 | Per-channel at-or-above-90% comparator flags |
| start_req | output | 2 | Per-channel start request |
| ramp_on | output | 2 | Per-channel soft-start ramp active |
| pgood_pull_dn | output | 1 | Open-drain pull-down enable for the supervisor line |

## Verification
The bench goes after the ordering edges. These are a second channel that starts while the first is not yet good, a gap of zero that still adds a wait, and a gap above 50 that is not clamped; each would show as an early or late rise of the second start request. Each soft-start select has its ramp length counted in ticks, so an off-by-one in the ramp counter shows up directly. In hold mode a short comparator glitch is forced, which catches a design that keeps its accumulated hold time or that lets the supervisor lag a drop by one cycle.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int POR_MS     = 10,
  parameter int HOLD_MS    = 125,
  parameter int GAP_MAX_MS = 50,
  parameter int GAP_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             uvlo_ok,
  input  logic [1:0]       hw_en,
  input  logic [1:0]       sw_en,
  input  logic [1:0]       seq_mode,
  input  logic [GAP_W-1:0] gap_ms,
  input  logic [1:0]       ramp_sel,
  input  logic             hold_mode,
  input  logic [1:0]       pg_in,
  output logic [1:0]       start_req,
  output logic [1:0]       ramp_on,
  output logic             pgood_pull_dn
);
  localparam int WAIT_T = 2 * POR_MS;
  localparam int HOLD_T = 2 * HOLD_MS;
  localparam int GAP_T  = 2 * GAP_MAX_MS;
  localparam int WW = $clog2(WAIT_T + 1);
  localparam int HW = $clog2(HOLD_T + 1);
  localparam int GW = $clog2(GAP_T + 1);

  logic [1:0]    en;
  logic          ready, first, lead_ok, gap_done, all_good, sup;
  logic [WW-1:0] wait_cnt;
  logic [GW-1:0] gap_cnt, gap_tgt;
  logic [HW-1:0] hold_cnt;
  logic [4:0]    ramp_len;
  logic [4:0]    rcnt [2];
  logic [1:0]    go;

  assign en       = hw_en & sw_en;
  assign ready    = uvlo_ok && (wait_cnt == WW'(WAIT_T));
  assign first    = (seq_mode == 2'b10);
  assign gap_tgt  = (int'(gap_ms) > GAP_MAX_MS) ? GW'(GAP_T) : GW'({gap_ms, 1'b0});
  assign lead_ok  = start_req[first] && pg_in[first];
  assign gap_done = lead_ok && (gap_cnt >= gap_tgt);
  assign all_good = ready && (en != 2'b00) && ((pg_in | ~en) == 2'b11);

  always_comb begin
    case (ramp_sel)
      2'd0:    ramp_len = 5'd1;
      2'd1:    ramp_len = 5'd2;
      2'd2:    ramp_len = 5'd8;
      default: ramp_len = 5'd16;
    endcase
  end

  always_comb begin
    case (seq_mode)
      2'b01:   go = {ready & en[1] & gap_done, ready & en[0]};
      2'b10:   go = {ready & en[1], ready & en[0] & gap_done};
      2'b11:   go = {2{ready & en[0] & en[1]}};
      default: go = {2{ready}} & en;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt  <= '0;
      gap_cnt   <= '0;
      hold_cnt  <= '0;
      start_req <= '0;
    end else begin
      start_req <= go;
      if (!uvlo_ok) wait_cnt <= '0;
      else if (tick && wait_cnt < WW'(WAIT_T)) wait_cnt <= wait_cnt + 1'b1;
      if (!lead_ok) gap_cnt <= '0;
      else if (tick && gap_cnt < gap_tgt) gap_cnt <= gap_cnt + 1'b1;
      if (!all_good) hold_cnt <= '0;
      else if (tick && hold_cnt < HW'(HOLD_T)) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_ramp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rcnt[i] <= '0;
      else if (!start_req[i]) rcnt[i] <= '0;
      else if (tick && rcnt[i] < ramp_len) rcnt[i] <= rcnt[i] + 1'b1;
    end
    assign ramp_on[i] = start_req[i] && (rcnt[i] < ramp_len);
  end

  assign sup           = hold_mode ? (all_good && hold_cnt == HW'(HOLD_T)) : all_good;
  assign pgood_pull_dn = ~sup;

  p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (start_req == 2'b00));
  p_drop_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en[0] == 1'b0) |=> !start_req[0]);
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start_req[1]) && $past(seq_mode) == 2'b01) |-> $past(pg_in[0] && start_req[0]));
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start_req[0]) && $past(seq_mode) == 2'b10) |-> $past(pg_in[1] && start_req[1]));
  p_ramp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_req[0]) |-> ramp_on[0]);
  p_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_mode && ready && en == 2'b11 && pg_in == 2'b11) |-> !pgood_pull_dn);
  p_break_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && $past(hold_mode) && $past(!all_good)) |-> pgood_pull_dn);
endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  logic clk = 0, rst_n = 0, tick = 0, uvlo_ok = 0, hold_mode = 0;
  logic [1:0] hw_en = 0, sw_en = 0, seq_mode = 0, ramp_sel = 0, pg_in = 0, force_low = 0;
  logic [5:0] gap_ms = 0;
  logic [1:0] start_req, ramp_on;
  logic pgood_pull_dn;
  int checks = 0, fails = 0, cyc = 0, tdiv = 0;
  string tag = "R1";

  int m_wait, m_gap, m_hold;
  int m_rc [2];
  bit [1:0] m_req;

  always #10 clk = ~clk;

  pwr_seq_ctrl uut (.clk, .rst_n, .tick, .uvlo_ok, .hw_en, .sw_en, .seq_mode,
    .gap_ms, .ramp_sel, .hold_mode, .pg_in, .start_req, .ramp_on, .pgood_pull_dn);

  function automatic int rlen(input bit [1:0] s);
    return s == 0 ? 1 : s == 1 ? 2 : s == 2 ? 8 : 16;
  endfunction
  function automatic int gtgt();
    return (gap_ms > 50 ? 50 : int'(gap_ms)) * 2;
  endfunction
  function automatic bit good_now();
    bit [1:0] e = hw_en & sw_en;
    return uvlo_ok && m_wait >= 20 && e != 0 && ((pg_in | ~e) == 2'b11);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait = 0; m_gap = 0; m_hold = 0; m_rc[0] = 0; m_rc[1] = 0; m_req = 0;
    end else begin
      bit [1:0] e, go;
      bit rdy, ag, gd;
      int f;
      e = hw_en & sw_en;
      rdy = uvlo_ok && m_wait >= 20;
      f = (seq_mode == 2'b10) ? 1 : 0;
      gd = m_req[f] && pg_in[f] && m_gap >= gtgt();
      ag = good_now();
      go = 0;
      if (rdy) begin
        if (seq_mode == 2'b00) go = e;
        else if (seq_mode == 2'b11) go = (e == 2'b11) ? 2'b11 : 2'b00;
        else begin
          go[f] = e[f];
          go[1-f] = e[1-f] && gd;
        end
      end
      if (m_req[f] && pg_in[f]) begin
        if (tick && m_gap < gtgt()) m_gap++;
      end else m_gap = 0;
      if (!uvlo_ok) m_wait = 0; else if (tick && m_wait < 20) m_wait++;
      for (int i = 0; i < 2; i++)
        if (!m_req[i]) m_rc[i] = 0; else if (tick && m_rc[i] < rlen(ramp_sel)) m_rc[i]++;
      if (!ag) m_hold = 0; else if (tick && m_hold < 250) m_hold++;
      m_req = go;
    end
  end

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", t, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    tdiv = (tdiv + 1) % 3;
    tick <= (tdiv == 0);
    if (rst_n) begin
      bit [1:0] er;
      bit sup;
      #1;
      for (int i = 0; i < 2; i++) er[i] = m_req[i] && m_rc[i] < rlen(ramp_sel);
      sup = hold_mode ? (good_now() && m_hold == 250) : good_now();
      check({tag, " start_req"}, start_req, m_req);
      check({tag, " R8 ramp_on"}, ramp_on, er);
      check({tag, " R11 pgood_pull_dn"}, pgood_pull_dn, !sup);
    end
  end

  always @(negedge clk) pg_in <= start_req & ~ramp_on & ~force_low;

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ramp_len_chk(input bit [1:0] sel, input int exp);
    int n = 0;
    hw_en = 0; run(3);
    ramp_sel = sel; seq_mode = 2'b00; hw_en = 2'b01;
    run(1);
    while (!ramp_on[0]) @(negedge clk);
    while (ramp_on[0]) begin #1; if (tick) n++; @(negedge clk); end
    check("R8 ramp ticks", n, exp);
  endtask

  initial begin
    run(3);
    #2;
    check("R1 reset start_req", start_req, 0);
    check("R11 reset pull-down", pgood_pull_dn, 1);
    rst_n = 1;
    tag = "R1"; hw_en = 2'b11; sw_en = 2'b11; seq_mode = 2'b01; gap_ms = 2;
    run(40);
    check("R1 held in lockout", start_req, 0);
    uvlo_ok = 1;
    run(55);
    check("R1 wait 20 ticks", start_req, 0);
    tag = "R3"; run(200);
    check("R3 both running", start_req, 2'b11);
    tag = "R2"; sw_en[0] = 0; run(2);
    check("R2 sw bit drop", start_req[0], 0);
    sw_en[0] = 1; hw_en[1] = 0; run(2);
    check("R2 hw pin drop", start_req[1], 0);
    hw_en = 0; run(3);
    tag = "R4"; seq_mode = 2'b10; gap_ms = 5; hw_en = 2'b11; run(250);
    tag = "R7"; hw_en = 0; run(3); gap_ms = 0; seq_mode = 2'b01; hw_en = 2'b11; run(60);
    hw_en = 0; run(3); gap_ms = 63; hw_en = 2'b11; run(400);
    check("R7 clamped gap done", start_req, 2'b11);
    tag = "R5"; hw_en = 0; run(3); seq_mode = 2'b11; hw_en = 2'b01; run(20);
    check("R5 waits for both", start_req, 0);
    hw_en = 2'b11; run(2);
    check("R5 together", start_req, 2'b11);
    tag = "R6"; hw_en = 0; run(3); seq_mode = 2'b00; hw_en = 2'b10; run(2);
    check("R6 independent", start_req, 2'b10);
    tag = "R8";
    ramp_len_chk(2'd0, 1); ramp_len_chk(2'd1, 2); ramp_len_chk(2'd2, 8); ramp_len_chk(2'd3, 16);
    tag = "R9"; hw_en = 2'b11; run(80);
    force_low[1] = 1; #2;
    check("R9 drop same cycle", pgood_pull_dn, 1);
    @(negedge clk); force_low[1] = 0; #2;
    check("R9 rise same cycle", pgood_pull_dn, 0);
    tag = "R10"; hold_mode = 1; run(400);
    force_low[0] = 1; run(2); force_low[0] = 0;
    run(700);
    check("R10 restarted hold not done", pgood_pull_dn, 1);
    run(150);
    check("R10 hold done", pgood_pull_dn, 0);
    uvlo_ok = 0; tag = "R1"; run(3);
    check("R1 lockout shutdown", start_req, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule